// File: doc/BRIEF.md
# Status Register Write Guard

This block keeps the protection bits of a serial flash status register and decides whether a write-status command may change them. The stored byte holds a lock-down bit and four block-protect bits. An incoming write is honoured only when the write-enable latch is set. It is refused when the lock-down bit is set and the hardware write-protect pin is asserted at the same time. If either condition is absent, the write goes through.

Each write request is settled in the clock edge that samples it. The outcome appears one cycle later as single-cycle accept or reject pulses. A third pulse tells the surrounding command logic to clear its write-enable latch. That pulse follows every write that was settled, whether it was accepted or refused. Bit positions not owned by this block always read as zero. Mapping block-protect values to address ranges is left to a neighbouring block, which reads them from the register output.

Top module: `sr_write_guard`

## Requirements
- R1: After reset, `sr_o` is 8'h00 and `acc_o`, `rej_o` and `wel_clr_o` are all 0.
- R2: With the write-protect pin deasserted (`wp_i` = 1 under the default active-low setting) and `wel_i` = 1, a write request loads bits 7 and 5..2 from `wr_data_i`. The new value is visible in the cycle after the request, together with an `acc_o` pulse.
- R3: With the pin asserted (`wp_i` = 0) and the stored lock-down bit (bit 7) at 0, a write with `wel_i` = 1 is accepted and loads the register.
- R4: With the pin asserted and the stored lock-down bit at 1, a write with `wel_i` = 1 is refused. `sr_o` keeps every bit, and `rej_o` is 1 for exactly one cycle after the request.
- R5: Bits 6, 1 and 0 of `sr_o` read 0 whatever value is written to them.
- R6: `wel_clr_o` pulses for one cycle after every request made with `wel_i` = 1, whether the write is accepted or refused.
- R7: A write request with `wel_i` = 0 is ignored. `sr_o` is unchanged and none of the three pulses appears.
- R8: `acc_o` and `rej_o` are never high together, and each returns to 0 in the cycle after its pulse when no new request arrives.
- R9: With the pin deasserted, a stored lock-down bit of 1 does not block a write, so the write can clear the lock-down bit.
- R10: The lock-down bit set by a write does not block that same write. It takes effect from the next request on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| wp_i | input | 1 | Hardware write-protect pin (active low by default) |
| wel_i | input | 1 | Write-enable latch state from command logic |
| wr_i | input | 1 | Write-status request, one cycle per command |
| wr_data_i | input | 8 | Byte carried by the write request |
| sr_o | output | 8 | Status register contents, unowned bits zero |
| acc_o | output | 1 | One-cycle pulse: write accepted |
| rej_o | output | 1 | One-cycle pulse: write refused by lock-down |
| wel_clr_o | output | 1 | One-cycle pulse: clear the write-enable latch |

## Verification
A wrong stored lock-down bit shows up at the next write made with the pin asserted. The pulse appears on the wrong flag one cycle after the request, and `sr_o` either changes or stays the same when the requirements say otherwise. A corrupted block-protect or unowned bit is visible on `sr_o` immediately. For that reason, the value on `sr_o` is checked after every request. The flags are checked both in the pulse cycle and in the following cycle, so that a stuck pulse is caught within one cycle.

// File: rtl/sr_guard_pkg.sv
package sr_guard_pkg;

   typedef enum logic [1:0] {
      VERDICT_NONE   = 2'd0,
      VERDICT_ACCEPT = 2'd1,
      VERDICT_REJECT = 2'd2
   } verdict_t;

   // Build the set of register bits owned by the guard: the lock-down bit
   // plus a contiguous block-protect field.
   function automatic logic [31:0] owned_bits(input int lock_bit,
                                              input int bp_lo,
                                              input int bp_w);
      logic [31:0] m;
      m = '0;
      m[lock_bit] = 1'b1;
      for (int i = 0; i < bp_w; i++) begin
         m[bp_lo + i] = 1'b1;
      end
      return m;
   endfunction

endpackage

// File: rtl/sr_guard_policy.sv
module sr_guard_policy
   import sr_guard_pkg::*;
#(
   parameter bit WP_ACTIVE_LOW = 1'b1
) (
   input  logic     wr,
   input  logic     wel,
   input  logic     wp,
   input  logic     lock_q,
   output verdict_t verdict
);

   logic pin_on;

   generate
      if (WP_ACTIVE_LOW) begin : g_pin_low
         assign pin_on = ~wp;
      end else begin : g_pin_high
         assign pin_on = wp;
      end
   endgenerate

   logic blocked;
   assign blocked = pin_on & lock_q;

   always_comb begin
      verdict = VERDICT_NONE;
      if (wr && wel) begin
         verdict = blocked ? VERDICT_REJECT : VERDICT_ACCEPT;
      end
   end

endmodule

// File: rtl/sr_guard_store.sv
module sr_guard_store #(
   parameter int             SR_W    = 8,
   parameter logic [SR_W-1:0] OWN_MASK = '0,
   parameter logic [SR_W-1:0] RST_VAL  = '0
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            load,
   input  logic [SR_W-1:0] wdata,
   output logic [SR_W-1:0] sr
);

   logic unused_wdata_bits;
   assign unused_wdata_bits = ^(wdata & ~OWN_MASK);

   generate
      for (genvar i = 0; i < SR_W; i++) begin : g_bit
         if (OWN_MASK[i]) begin : g_held
            logic q;
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) begin
                  q <= RST_VAL[i];
               end else if (load) begin
                  q <= wdata[i];
               end
            end
            assign sr[i] = q;
         end else begin : g_zero
            assign sr[i] = 1'b0;
         end
      end
   endgenerate

endmodule

// File: rtl/sr_guard_pulse.sv
module sr_guard_pulse
   import sr_guard_pkg::*;
(
   input  logic     clk,
   input  logic     rst_n,
   input  verdict_t verdict,
   output logic     acc,
   output logic     rej,
   output logic     wel_clr
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         acc     <= 1'b0;
         rej     <= 1'b0;
         wel_clr <= 1'b0;
      end else begin
         acc     <= (verdict == VERDICT_ACCEPT);
         rej     <= (verdict == VERDICT_REJECT);
         wel_clr <= (verdict != VERDICT_NONE);
      end
   end

endmodule

// File: rtl/sr_write_guard.sv
module sr_write_guard
   import sr_guard_pkg::*;
#(
   parameter int SR_W          = 8,
   parameter int LOCK_BIT      = 7,
   parameter int BP_LO         = 2,
   parameter int BP_W          = 4,
   parameter bit WP_ACTIVE_LOW = 1'b1,
   parameter logic [SR_W-1:0] RST_VAL = '0
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            wp_i,
   input  logic            wel_i,
   input  logic            wr_i,
   input  logic [SR_W-1:0] wr_data_i,
   output logic [SR_W-1:0] sr_o,
   output logic            acc_o,
   output logic            rej_o,
   output logic            wel_clr_o
);

   localparam int BP_HI = BP_LO + BP_W - 1;
   localparam logic [SR_W-1:0] OWN_MASK = SR_W'(owned_bits(LOCK_BIT, BP_LO, BP_W));

   initial begin
      if (SR_W < 2 || SR_W > 32)
         $error("sr_write_guard: SR_W out of range");
      if (LOCK_BIT < 0 || LOCK_BIT >= SR_W)
         $error("sr_write_guard: LOCK_BIT outside register");
      if (BP_W < 1 || BP_LO < 0 || BP_HI >= SR_W)
         $error("sr_write_guard: block-protect field outside register");
      if (LOCK_BIT >= BP_LO && LOCK_BIT <= BP_HI)
         $error("sr_write_guard: lock-down bit overlaps block-protect field");
   end

   verdict_t verdict;

   sr_guard_policy #(
      .WP_ACTIVE_LOW(WP_ACTIVE_LOW)
   ) u_policy (
      .wr     (wr_i),
      .wel    (wel_i),
      .wp     (wp_i),
      .lock_q (sr_o[LOCK_BIT]),
      .verdict(verdict)
   );

   sr_guard_store #(
      .SR_W    (SR_W),
      .OWN_MASK(OWN_MASK),
      .RST_VAL (RST_VAL & OWN_MASK)
   ) u_store (
      .clk  (clk),
      .rst_n(rst_n),
      .load (verdict == VERDICT_ACCEPT),
      .wdata(wr_data_i),
      .sr   (sr_o)
   );

   sr_guard_pulse u_pulse (
      .clk    (clk),
      .rst_n  (rst_n),
      .verdict(verdict),
      .acc    (acc_o),
      .rej    (rej_o),
      .wel_clr(wel_clr_o)
   );

endmodule

// File: rtl/sr_write_guard_chk.sv
module sr_write_guard_chk #(
   parameter int SR_W          = 8,
   parameter int LOCK_BIT      = 7,
   parameter int BP_LO         = 2,
   parameter int BP_W          = 4,
   parameter bit WP_ACTIVE_LOW = 1'b1
) (
   input logic            clk,
   input logic            rst_n,
   input logic            wp_i,
   input logic            wel_i,
   input logic            wr_i,
   input logic [SR_W-1:0] wr_data_i,
   input logic [SR_W-1:0] sr_o,
   input logic            acc_o,
   input logic            rej_o,
   input logic            wel_clr_o
);

   localparam logic [SR_W-1:0] MASK =
      SR_W'(sr_guard_pkg::owned_bits(LOCK_BIT, BP_LO, BP_W));

   logic pin_on;
   assign pin_on = WP_ACTIVE_LOW ? !wp_i : wp_i;

   // R4: pin asserted with lock-down set leads to a refusal
   assert_locked_reject_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_i && wel_i && pin_on && sr_o[LOCK_BIT]) |=> (rej_o && !acc_o));

   // R4: a refusal leaves the register as it was
   assert_reject_keeps_R4: assert property (@(posedge clk) disable iff (!rst_n)
      rej_o |-> $stable(sr_o));

   // R2, R3, R9: unblocked write loads the owned bits
   assert_accept_loads_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_i && wel_i && !(pin_on && sr_o[LOCK_BIT]))
         |=> (acc_o && sr_o == ($past(wr_data_i) & MASK)));

   // R7: no write-enable, no effect
   assert_no_wel_ignored_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_i && !wel_i) |=> (!acc_o && !rej_o && !wel_clr_o && $stable(sr_o)));

   // R6: every settled write asks for the latch to be cleared
   assert_clear_latch_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (acc_o || rej_o) |-> wel_clr_o);

   // R8: outcomes exclusive
   assert_exclusive_R8: assert property (@(posedge clk) disable iff (!rst_n)
      !(acc_o && rej_o));

endmodule

bind sr_write_guard sr_write_guard_chk #(
   .SR_W         (SR_W),
   .LOCK_BIT     (LOCK_BIT),
   .BP_LO        (BP_LO),
   .BP_W         (BP_W),
   .WP_ACTIVE_LOW(WP_ACTIVE_LOW)
) u_chk (.*);

// File: tb/sr_write_guard_tb.sv
`timescale 1ns/1ps
module sr_write_guard_tb;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       wp_i = 1'b1;
   logic       wel_i = 1'b0;
   logic       wr_i = 1'b0;
   logic [7:0] wr_data_i = 8'h00;
   logic [7:0] sr_o;
   logic       acc_o, rej_o, wel_clr_o;

   int checks = 0;
   int errors = 0;
   logic [7:0] exp_sr = 8'h00;
   bit done = 1'b0;

   always #2.5 clk = ~clk;

   sr_write_guard u_dut (
      .clk(clk), .rst_n(rst_n), .wp_i(wp_i), .wel_i(wel_i), .wr_i(wr_i),
      .wr_data_i(wr_data_i), .sr_o(sr_o), .acc_o(acc_o), .rej_o(rej_o),
      .wel_clr_o(wel_clr_o)
   );

   task automatic chk(input string req, input string what,
                      input logic [7:0] got, input logic [7:0] exp);
      checks++;
      if (got !== exp) begin
         errors++;
         $display("FAIL %s %s: got %h expected %h", req, what, got, exp);
      end
   endtask

   // One request; returns sampled at the negedge after the capturing edge.
   task automatic do_write(input logic wp, input logic wel, input logic [7:0] d,
                           input string req, input logic e_acc, input logic e_rej,
                           input logic e_clr);
      @(negedge clk);
      wp_i = wp; wel_i = wel; wr_i = 1'b1; wr_data_i = d;
      @(negedge clk);
      wr_i = 1'b0; wel_i = 1'b0;
      chk(req, "sr_o", sr_o, exp_sr);
      chk(req, "acc_o", {7'd0, acc_o}, {7'd0, e_acc});
      chk(req, "rej_o", {7'd0, rej_o}, {7'd0, e_rej});
      chk(req, "wel_clr_o", {7'd0, wel_clr_o}, {7'd0, e_clr});
      @(negedge clk);
      chk("R8", "acc_o after pulse", {7'd0, acc_o}, 8'h00);
      chk("R8", "rej_o after pulse", {7'd0, rej_o}, 8'h00);
      chk(req, "sr_o held", sr_o, exp_sr);
   endtask

   task automatic t_reset;
      chk("R1", "sr_o", sr_o, 8'h00);
      chk("R1", "flags", {5'd0, acc_o, rej_o, wel_clr_o}, 8'h00);
   endtask

   task automatic t_pin_off_write;   // R2, R5, R6
      exp_sr = 8'hBC;
      do_write(1'b1, 1'b1, 8'hFF, "R2", 1'b1, 1'b0, 1'b1);
   endtask

   task automatic t_pin_off_clears_lock;   // R9
      exp_sr = 8'h14;
      do_write(1'b1, 1'b1, 8'h14, "R9", 1'b1, 1'b0, 1'b1);
   endtask

   task automatic t_pin_on_unlocked;   // R3, R10
      exp_sr = 8'hA8;
      do_write(1'b0, 1'b1, 8'hA8, "R3", 1'b1, 1'b0, 1'b1);
      chk("R10", "lock bit now set", {7'd0, sr_o[7]}, 8'h01);
   endtask

   task automatic t_pin_on_locked;   // R4, R6
      do_write(1'b0, 1'b1, 8'h00, "R4", 1'b0, 1'b1, 1'b1);
      do_write(1'b0, 1'b1, 8'h3C, "R4", 1'b0, 1'b1, 1'b1);
   endtask

   task automatic t_no_wel;   // R7
      do_write(1'b1, 1'b0, 8'h00, "R7", 1'b0, 1'b0, 1'b0);
      do_write(1'b0, 1'b0, 8'h00, "R7", 1'b0, 1'b0, 1'b0);
   endtask

   task automatic t_unowned_bits;   // R5
      exp_sr = 8'h00;
      do_write(1'b1, 1'b1, 8'h43, "R5", 1'b1, 1'b0, 1'b1);
      exp_sr = 8'h24;
      do_write(1'b0, 1'b1, 8'h67, "R5", 1'b1, 1'b0, 1'b1);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      t_reset;
      rst_n = 1'b1;
      @(negedge clk);
      t_reset;
      t_pin_off_write;
      t_pin_off_clears_lock;
      t_pin_on_unlocked;
      t_pin_on_locked;
      t_no_wel;
      exp_sr = 8'h00;
      do_write(1'b1, 1'b1, 8'h00, "R9", 1'b1, 1'b0, 1'b1);
      t_unowned_bits;
      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      #50000;
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog: got timeout expected completion");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

endmodule